// File: doc/BRIEF.md
# Exhaustive Fault-Injection Coverage Engine

This block grades a fixed test strategy against a small combinational circuit. It holds two copies of a four-input gate network whose output is the complement of (((A OR B) AND C) AND D). One copy is always fault-free. The other copy takes one injected fault at a time. The fault can hold a node at a constant, or it can short two nodes together so that either 0 or 1 wins.

After a start pulse, the engine steps through every fault identifier. It skips identifiers that are not well formed or whose fault class is masked off. For each remaining fault it applies the sixteen input vectors in ascending order and compares the two outputs. It stops on the first difference. It reports one record per fault, keeps a running detected/considered tally, and at the end divides to give an integer coverage percentage.

The block is used as a self-contained hardware fault grader. Software or a test sequencer chooses the fault classes, pulses start, collects the per-fault records, and reads the totals when done pulses.

Top module: `fic_coverage_eval`

## Requirements
- R1: After reset, busy, done and res_valid are 0, and det_count, total_count and coverage are 0.
- R2: Circuit nodes are numbered A=0, B=1, C=2, D=3, Z=4 (A OR B), X=5 (NOT(Z AND C)), Y=6 (NOT X) and OUT=7 (NOT(Y AND D)). A vector v drives A=v[0], B=v[1], C=v[2] and D=v[3]. Vectors are applied as 0 to 15 in ascending order. Worked example: stuck-at-1 on OUT is first exposed by vector 13.
- R3: A fault identifier is 8 bits, {kind[7:6], na[5:3], nb[2:0]}. The kinds are 00 stuck-at-0, 01 stuck-at-1, 10 wired-AND and 11 wired-OR. A stuck-at identifier is well formed only when nb=0. A bridge identifier is well formed only when na<nb. Identifiers are visited in ascending order from 0 to 255. With all kinds enabled, 72 faults are considered.
- R4: A stuck-at fault forces node na to the constant, and every node downstream is computed from the forced value. Worked example: stuck-at-0 on OUT is exposed by vector 0.
- R5: A bridge drives both na and nb to the AND (wired-AND) or the OR (wired-OR) of their fault-free values for the current vector. The other nodes are computed from the faulty values feeding them. Worked examples: a wired-AND of A and B is first exposed by vector 13, and a wired-OR of A and B is never exposed.
- R6: A fault is detected at the first vector where the faulty output differs from the fault-free output, and its sweep stops there. Its record carries res_hit=1 and res_vec set to that vector. A fault with no difference over all 16 vectors reports res_hit=0 and res_vec=0.
- R7: type_en is sampled on the accepted start pulse, with bit k enabling kind k. Faults of a disabled kind produce no record and are not counted.
- R8: det_count and total_count hold the number of detected faults and the number of considered faults of the last sweep, and det_count never exceeds total_count.
- R9: When a sweep ends, done pulses for one cycle. coverage then holds floor(det_count*100/total_count), or 0 when total_count is 0.
- R10: A start pulse while busy is ignored, and the sweep continues unchanged.
- R11: Exactly one res_valid pulse is issued per considered fault, in ascending identifier order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sweep when idle |
| type_en | input | 4 | Enable mask per fault kind |
| busy | output | 1 | Sweep or division in progress |
| done | output | 1 | One-cycle pulse at end of sweep |
| res_valid | output | 1 | Per-fault record strobe |
| res_fault | output | 8 | Identifier of the reported fault |
| res_hit | output | 1 | Fault was detected |
| res_vec | output | 4 | First exposing vector, or 0 |
| det_count | output | 9 | Detected faults |
| total_count | output | 9 | Considered faults |
| coverage | output | 7 | Integer coverage percentage |

## Verification
On every cycle, the embedded assertions check four things. The detected tally never overtakes the considered tally. Records only name enabled fault kinds. A start pulse during a sweep never rewinds the counts. The division yields an in-range quotient with a remainder below the divisor. Whether each fault is graded correctly can only be shown by the bench's directed sweeps, which compare every record with an independent model of the circuit and its fault semantics. The same applies to the first exposing vector, the skipping of malformed identifiers, the class masking and the final percentage.

// File: rtl/fic_pkg.sv
package fic_pkg;
  localparam int N_IN   = 4;
  localparam int N_NODE = 8;
  localparam int NODE_W = $clog2(N_NODE);
  localparam int FID_W  = 2 + 2*NODE_W;
  localparam int N_PAT  = 1 << N_IN;

  typedef enum logic [1:0] {
    K_SA0  = 2'b00,
    K_SA1  = 2'b01,
    K_WAND = 2'b10,
    K_WOR  = 2'b11
  } fkind_e;

  typedef struct packed {
    fkind_e              kind;
    logic [NODE_W-1:0]   na;
    logic [NODE_W-1:0]   nb;
  } fault_t;

  localparam logic [NODE_W-1:0] ND_A   = 3'd0;
  localparam logic [NODE_W-1:0] ND_B   = 3'd1;
  localparam logic [NODE_W-1:0] ND_C   = 3'd2;
  localparam logic [NODE_W-1:0] ND_D   = 3'd3;
  localparam logic [NODE_W-1:0] ND_Z   = 3'd4;
  localparam logic [NODE_W-1:0] ND_X   = 3'd5;
  localparam logic [NODE_W-1:0] ND_Y   = 3'd6;
  localparam logic [NODE_W-1:0] ND_OUT = 3'd7;

  function automatic logic is_bridge(fault_t f);
    return f.kind[1];
  endfunction

  function automatic logic fault_ok(fault_t f);
    if (!f.kind[1]) return (f.nb == '0);
    return (f.na < f.nb);
  endfunction
endpackage

// File: rtl/fic_cut.sv
module fic_cut
  import fic_pkg::*;
(
  input  logic [N_IN-1:0] vec,
  input  fault_t          fault,
  input  logic            fault_on,
  output logic            out
);
  logic g_a, g_b, g_c, g_d, g_z, g_x, g_y, g_out;
  logic [N_NODE-1:0] gvec;
  logic [N_NODE-1:0] frc_mask;
  logic              frc_val;
  logic              brg;
  logic f_a, f_b, f_c, f_d, f_z, f_x, f_y, f_out;

  // fault-free evaluation, used as the source for bridge values
  assign g_a   = vec[0];
  assign g_b   = vec[1];
  assign g_c   = vec[2];
  assign g_d   = vec[3];
  assign g_z   = g_a | g_b;
  assign g_x   = ~(g_z & g_c);
  assign g_y   = ~g_x;
  assign g_out = ~(g_y & g_d);
  assign gvec  = {g_out, g_y, g_x, g_z, g_d, g_c, g_b, g_a};

  assign brg = is_bridge(fault);

  for (genvar n = 0; n < N_NODE; n++) begin : g_frc
    assign frc_mask[n] = fault_on &&
                         ((fault.na == NODE_W'(n)) ||
                          (brg && (fault.nb == NODE_W'(n))));
  end

  always_comb begin
    unique case (fault.kind)
      K_SA0:   frc_val = 1'b0;
      K_SA1:   frc_val = 1'b1;
      K_WAND:  frc_val = gvec[fault.na] & gvec[fault.nb];
      default: frc_val = gvec[fault.na] | gvec[fault.nb];
    endcase
  end

  // faulty evaluation in topological order
  assign f_a   = frc_mask[ND_A]   ? frc_val : vec[0];
  assign f_b   = frc_mask[ND_B]   ? frc_val : vec[1];
  assign f_c   = frc_mask[ND_C]   ? frc_val : vec[2];
  assign f_d   = frc_mask[ND_D]   ? frc_val : vec[3];
  assign f_z   = frc_mask[ND_Z]   ? frc_val : (f_a | f_b);
  assign f_x   = frc_mask[ND_X]   ? frc_val : ~(f_z & f_c);
  assign f_y   = frc_mask[ND_Y]   ? frc_val : ~f_x;
  assign f_out = frc_mask[ND_OUT] ? frc_val : ~(f_y & f_d);
  assign out   = f_out;

  always_comb begin
    if (fault_on && !brg && fault.na == ND_OUT)
      AST_SA_ON_OUTPUT: assert (out == fault.kind[0]); // R4
    if (!fault_on)
      AST_NO_FORCE_WHEN_OFF: assert (frc_mask == '0); // R2
  end
endmodule

// File: rtl/fic_divider.sv
module fic_divider #(
  parameter int NUM_W = 16,
  parameter int DEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             valid,
  output logic [NUM_W-1:0] quot
);
  localparam int CW = $clog2(NUM_W + 1);

  logic             run_q, run_d;
  logic             val_q, val_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [DEN_W:0]   rem_q, rem_d;
  logic [NUM_W-1:0] quo_q, quo_d;
  logic [DEN_W-1:0] den_q, den_d;
  logic [DEN_W:0]   shifted;
  logic [DEN_W+1:0] trial;
  logic             ge;

  assign shifted = {rem_q[DEN_W-1:0], quo_q[NUM_W-1]};
  assign trial   = {1'b0, shifted} - {2'b00, den_q};
  assign ge      = ~trial[DEN_W+1];

  always_comb begin
    run_d = run_q;
    val_d = 1'b0;
    cnt_d = cnt_q;
    rem_d = rem_q;
    quo_d = quo_q;
    den_d = den_q;
    if (start && !run_q) begin
      run_d = 1'b1;
      cnt_d = CW'(NUM_W);
      rem_d = '0;
      quo_d = num;
      den_d = den;
    end else if (run_q) begin
      rem_d = ge ? trial[DEN_W:0] : shifted;
      quo_d = {quo_q[NUM_W-2:0], ge};
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_d = 1'b0;
        val_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      val_q <= 1'b0;
      cnt_q <= '0;
      rem_q <= '0;
      quo_q <= '0;
      den_q <= '0;
    end else begin
      run_q <= run_d;
      val_q <= val_d;
      cnt_q <= cnt_d;
      if (run_q || start) begin
        rem_q <= rem_d;
        quo_q <= quo_d;
        den_q <= den_d;
      end
    end
  end

  assign valid = val_q;
  assign quot  = quo_q;

  AST_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (rem_q < {1'b0, den_q})); // R9
endmodule

// File: rtl/fic_sweep.sv
module fic_sweep
  import fic_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int COV_W = 7,
  parameter int NUM_W = CNT_W + COV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       type_en,
  input  logic             mismatch,
  input  logic             div_valid,
  input  logic [NUM_W-1:0] div_quot,
  output fault_t           cur_fault,
  output logic [N_IN-1:0]  cur_vec,
  output logic             div_start,
  output logic [NUM_W-1:0] div_num,
  output logic [CNT_W-1:0] div_den,
  output logic             busy,
  output logic             done,
  output logic             res_valid,
  output logic [FID_W-1:0] res_fault,
  output logic             res_hit,
  output logic [N_IN-1:0]  res_vec,
  output logic [CNT_W-1:0] det_count,
  output logic [CNT_W-1:0] total_count,
  output logic [COV_W-1:0] coverage
);
  localparam int PCT = 100;

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_LAUNCH, S_DIV} st_e;

  st_e              st_q, st_d;
  logic [FID_W-1:0] fid_q, fid_d;
  logic [N_IN-1:0]  pat_q, pat_d;
  logic [3:0]       en_q, en_d;
  logic [CNT_W-1:0] det_q, det_d, tot_q, tot_d;
  logic [COV_W-1:0] cov_q, cov_d;
  logic             done_q, done_d;
  logic             rv_q, rv_d;
  logic [FID_W-1:0] rf_q;
  logic             rh_q, rh_d;
  logic [N_IN-1:0]  rvec_q, rvec_d;
  logic             considered, fault_end;
  fault_t           rf_view;

  assign cur_fault  = fault_t'(fid_q);
  assign cur_vec    = pat_q;
  assign considered = fault_ok(cur_fault) && en_q[cur_fault.kind];
  assign rf_view    = fault_t'(rf_q);

  always_comb begin
    st_d      = st_q;
    fid_d     = fid_q;
    pat_d     = pat_q;
    en_d      = en_q;
    det_d     = det_q;
    tot_d     = tot_q;
    cov_d     = cov_q;
    done_d    = 1'b0;
    rv_d      = 1'b0;
    rh_d      = 1'b0;
    rvec_d    = '0;
    div_start = 1'b0;
    fault_end = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (start) begin
          st_d  = S_SCAN;
          en_d  = type_en;
          fid_d = '0;
          pat_d = '0;
          det_d = '0;
          tot_d = '0;
          cov_d = '0;
        end
      end
      S_SCAN: begin
        if (!considered) begin
          fault_end = 1'b1;
        end else if (mismatch) begin
          rv_d      = 1'b1;
          rh_d      = 1'b1;
          rvec_d    = pat_q;
          det_d     = det_q + 1'b1;
          tot_d     = tot_q + 1'b1;
          fault_end = 1'b1;
        end else if (&pat_q) begin
          rv_d      = 1'b1;
          tot_d     = tot_q + 1'b1;
          fault_end = 1'b1;
        end else begin
          pat_d = pat_q + 1'b1;
        end
        if (fault_end) begin
          pat_d = '0;
          fid_d = fid_q + 1'b1;
          if (&fid_q) st_d = S_LAUNCH;
        end
      end
      S_LAUNCH: begin
        if (tot_q == '0) begin
          cov_d  = '0;
          done_d = 1'b1;
          st_d   = S_IDLE;
        end else begin
          div_start = 1'b1;
          st_d      = S_DIV;
        end
      end
      default: begin
        if (div_valid) begin
          cov_d  = div_quot[COV_W-1:0];
          done_d = 1'b1;
          st_d   = S_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      fid_q  <= '0;
      pat_q  <= '0;
      en_q   <= '0;
      det_q  <= '0;
      tot_q  <= '0;
      cov_q  <= '0;
      done_q <= 1'b0;
      rv_q   <= 1'b0;
      rf_q   <= '0;
      rh_q   <= 1'b0;
      rvec_q <= '0;
    end else begin
      st_q   <= st_d;
      fid_q  <= fid_d;
      pat_q  <= pat_d;
      en_q   <= en_d;
      det_q  <= det_d;
      tot_q  <= tot_d;
      cov_q  <= cov_d;
      done_q <= done_d;
      rv_q   <= rv_d;
      if (rv_d) begin
        rf_q   <= fid_q;
        rh_q   <= rh_d;
        rvec_q <= rvec_d;
      end
    end
  end

  assign div_num     = NUM_W'(det_q) * NUM_W'(PCT);
  assign div_den     = tot_q;
  assign busy        = (st_q != S_IDLE);
  assign done        = done_q;
  assign res_valid   = rv_q;
  assign res_fault   = rf_q;
  assign res_hit     = rh_q;
  assign res_vec     = rvec_q;
  assign det_count   = det_q;
  assign total_count = tot_q;
  assign coverage    = cov_q;

  AST_DET_LE_TOT: assert property (@(posedge clk) disable iff (!rst_n)
    det_q <= tot_q); // R8
  AST_RECORD_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    rv_q |-> (en_q[rf_view.kind] && fault_ok(rf_view))); // R7
  AST_START_NO_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_SCAN && start) |=> (tot_q >= $past(tot_q))); // R10
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(busy)); // R9
  AST_COV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cov_q <= COV_W'(PCT))); // R9
  AST_QUOT_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    div_valid |-> (div_quot[NUM_W-1:COV_W] == '0)); // R9
endmodule

// File: rtl/fic_coverage_eval.sv
module fic_coverage_eval
  import fic_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int COV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       type_en,
  output logic             busy,
  output logic             done,
  output logic             res_valid,
  output logic [FID_W-1:0] res_fault,
  output logic             res_hit,
  output logic [N_IN-1:0]  res_vec,
  output logic [CNT_W-1:0] det_count,
  output logic [CNT_W-1:0] total_count,
  output logic [COV_W-1:0] coverage
);
  localparam int NUM_W = CNT_W + COV_W;

  logic [1:0]       rs_q;
  logic             rst_i_n;
  fault_t           cur_fault;
  fault_t           no_fault;
  logic [N_IN-1:0]  cur_vec;
  logic             gold_out, flt_out, mismatch;
  logic             div_start, div_valid;
  logic [NUM_W-1:0] div_num, div_quot;
  logic [CNT_W-1:0] div_den;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  assign no_fault = '0;

  fic_cut i_gold (
    .vec      (cur_vec),
    .fault    (no_fault),
    .fault_on (1'b0),
    .out      (gold_out)
  );

  fic_cut i_faulty (
    .vec      (cur_vec),
    .fault    (cur_fault),
    .fault_on (1'b1),
    .out      (flt_out)
  );

  assign mismatch = gold_out ^ flt_out;

  fic_sweep #(.CNT_W(CNT_W), .COV_W(COV_W), .NUM_W(NUM_W)) i_sweep (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .start       (start),
    .type_en     (type_en),
    .mismatch    (mismatch),
    .div_valid   (div_valid),
    .div_quot    (div_quot),
    .cur_fault   (cur_fault),
    .cur_vec     (cur_vec),
    .div_start   (div_start),
    .div_num     (div_num),
    .div_den     (div_den),
    .busy        (busy),
    .done        (done),
    .res_valid   (res_valid),
    .res_fault   (res_fault),
    .res_hit     (res_hit),
    .res_vec     (res_vec),
    .det_count   (det_count),
    .total_count (total_count),
    .coverage    (coverage)
  );

  fic_divider #(.NUM_W(NUM_W), .DEN_W(CNT_W)) i_div (
    .clk   (clk),
    .rst_n (rst_i_n),
    .start (div_start),
    .num   (div_num),
    .den   (div_den),
    .valid (div_valid),
    .quot  (div_quot)
  );
endmodule

// File: tb/test_fic_coverage_eval.sv
module test_fic_coverage_eval;
  logic       clk;
  logic       rst_n;
  logic       start;
  logic [3:0] type_en;
  logic       busy, done, res_valid, res_hit;
  logic [7:0] res_fault;
  logic [3:0] res_vec;
  logic [8:0] det_count, total_count;
  logic [6:0] coverage;

  int checks = 0;
  int errors = 0;

  fic_coverage_eval i_fic_coverage_eval (
    .clk(clk), .rst_n(rst_n), .start(start), .type_en(type_en),
    .busy(busy), .done(done), .res_valid(res_valid), .res_fault(res_fault),
    .res_hit(res_hit), .res_vec(res_vec), .det_count(det_count),
    .total_count(total_count), .coverage(coverage)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit id_ok(int id);
    int kind = (id >> 6) & 3;
    int na = (id >> 3) & 7;
    int nb = id & 7;
    if (kind < 2) return nb == 0;
    return na < nb;
  endfunction

  // reference circuit with optional single fault
  function automatic bit model(int v, int id, bit faulty);
    bit g[8];
    bit f[8];
    bit m[8];
    bit fv;
    int kind = (id >> 6) & 3;
    int na = (id >> 3) & 7;
    int nb = id & 7;
    for (int i = 0; i < 4; i++) g[i] = v[i];
    g[4] = g[0] | g[1];
    g[5] = !(g[4] & g[2]);
    g[6] = !g[5];
    g[7] = !(g[6] & g[3]);
    if (!faulty) return g[7];
    for (int i = 0; i < 8; i++) m[i] = 0;
    m[na] = 1;
    if (kind >= 2) m[nb] = 1;
    case (kind)
      0: fv = 0;
      1: fv = 1;
      2: fv = g[na] & g[nb];
      default: fv = g[na] | g[nb];
    endcase
    for (int i = 0; i < 4; i++) f[i] = m[i] ? fv : v[i];
    f[4] = m[4] ? fv : (f[0] | f[1]);
    f[5] = m[5] ? fv : !(f[4] & f[2]);
    f[6] = m[6] ? fv : !f[5];
    f[7] = m[7] ? fv : !(f[6] & f[3]);
    return f[7];
  endfunction

  function automatic int first_hit(int id);
    for (int p = 0; p < 16; p++)
      if (model(p, id, 1'b1) != model(p, id, 1'b0)) return p;
    return 16;
  endfunction

  function automatic int next_id(int from, logic [3:0] en);
    for (int i = from; i < 256; i++)
      if (id_ok(i) && en[(i >> 6) & 3]) return i;
    return 256;
  endfunction

  task automatic run_sweep(input logic [3:0] en, input string tag, input bit poke);
    int exp_id, exp_det, exp_tot, exp_cov, fp;
    bit fin;
    exp_det = 0;
    exp_tot = 0;
    for (int i = 0; i < 256; i++) begin
      if (id_ok(i) && en[(i >> 6) & 3]) begin
        exp_tot++;
        if (first_hit(i) < 16) exp_det++;
      end
    end
    exp_cov = (exp_tot == 0) ? 0 : (exp_det * 100) / exp_tot;
    exp_id = next_id(0, en);
    @(negedge clk);
    type_en = en;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    type_en = 4'h0;
    fin = 0;
    for (int cyc = 0; cyc < 6000 && !fin; cyc++) begin
      start = (poke && (cyc == 40 || cyc == 41 || cyc == 300));
      if (res_valid) begin
        fp = first_hit(exp_id);
        check(res_fault == exp_id, {tag, " R11 record order"}, res_fault, exp_id);
        check(res_hit == (fp < 16) && res_vec == ((fp < 16) ? fp : 0),
              {tag, " R6 R4 R5 hit/vector"}, {res_hit, res_vec}, {(fp < 16), ((fp < 16) ? fp : 0)});
        if (res_fault == 8'h78)
          check(res_hit && res_vec == 13, {tag, " R2 SA1 on OUT vector"}, res_vec, 13);
        if (res_fault == 8'h38)
          check(res_hit && res_vec == 0, {tag, " R4 SA0 on OUT vector"}, res_vec, 0);
        if (res_fault == 8'h81)
          check(res_hit && res_vec == 13, {tag, " R5 wired-AND A,B vector"}, res_vec, 13);
        if (res_fault == 8'hC1)
          check(!res_hit && res_vec == 0, {tag, " R5 wired-OR A,B undetected"}, res_hit, 0);
        exp_id = next_id(exp_id + 1, en);
      end
      if (done) fin = 1;
      else @(negedge clk);
    end
    start = 1'b0;
    check(fin, {tag, " R9 done pulse seen"}, fin, 1);
    check(exp_id == 256, {tag, " R11 all records seen"}, exp_id, 256);
    check(det_count == exp_det, {tag, " R8 detected count"}, det_count, exp_det);
    check(total_count == exp_tot, {tag, " R3 R7 considered count"}, total_count, exp_tot);
    check(coverage == exp_cov, {tag, " R9 coverage percent"}, coverage, exp_cov);
    @(negedge clk);
    check(!done && !busy, {tag, " R9 done is one cycle"}, {done, busy}, 0);
  endtask

  task automatic test_reset();
    check(!busy && !done && !res_valid, "R1 reset control", {busy, done, res_valid}, 0);
    check(det_count == 0 && total_count == 0 && coverage == 0, "R1 reset counts",
          det_count + total_count + coverage, 0);
  endtask

  task automatic test_full();
    run_sweep(4'hF, "full", 1'b0);
    check(total_count == 72, "R3 full list size", total_count, 72);
  endtask

  task automatic test_stuck_only();
    run_sweep(4'h3, "stuck", 1'b0);
    check(total_count == 16, "R7 stuck-at only count", total_count, 16);
  endtask

  task automatic test_bridge_and();
    run_sweep(4'h4, "wand", 1'b0);
    check(total_count == 28, "R7 wired-AND only count", total_count, 28);
  endtask

  task automatic test_bridge_or();
    run_sweep(4'h8, "wor", 1'b0);
  endtask

  task automatic test_none();
    run_sweep(4'h0, "none", 1'b0);
    check(coverage == 0, "R9 zero total gives zero coverage", coverage, 0);
  endtask

  task automatic test_restart_ignored();
    run_sweep(4'hF, "poke", 1'b1);
    check(total_count == 72, "R10 start while busy ignored", total_count, 72);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    type_en = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    test_full();
    test_stuck_only();
    test_bridge_and();
    test_bridge_or();
    test_none();
    test_restart_ignored();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule